// File: doc/BRIEF.md
# Oversampling Bus Input Synchronizer

This block brings a group of slow asynchronous bus lines into a fast system clock domain. The bus lines toggle at about 1 MHz and the system clock runs near 100 MHz. Each raw line first crosses into the clock domain through a two-flop synchronizer. A free-running divider then produces a sample strobe once every `DIV` system clocks, which is about 4 MHz with the default ratio of 25. Sampling well above twice the bus rate lets the block see every real level change.

Each line is tracked by its own four-state filter machine, and only strobe cycles move it. The states are `ST_LOW` (settled low), `ST_LOW_PEND` (settled low, one high sample seen), `ST_HIGH` (settled high) and `ST_HIGH_PEND` (settled high, one low sample seen). These are the transitions:
- A strobe with a high sample moves `ST_LOW` to `ST_LOW_PEND`.
- A strobe with a low sample moves `ST_LOW_PEND` back to `ST_LOW`, and one with a high sample confirms the rise to `ST_HIGH`.
- A strobe with a low sample moves `ST_HIGH` to `ST_HIGH_PEND`.
- A strobe with a high sample moves `ST_HIGH_PEND` back to `ST_HIGH`, and one with a low sample confirms the fall to `ST_LOW`.

A filtered level therefore changes only after two successive samples agree. A line enabled in `EDGE_MASK` also gives a one-clock rise or fall pulse on the confirming strobe. Downstream synchronous logic uses the levels and pulses in place of the raw pins.

Top module: `bus_oversampler`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the divider and every filter machine. In the cycle after such an edge, every `level_o` bit is 0 and every `rise_o` and `fall_o` bit is 0.
- R2: The divider counts 0 to `DIV`-1 and wraps, and its strobe is active while the count is `DIV`-1. Call the n-th rising edge after reset release edge n. Outputs can change only at edges where n is a multiple of `DIV`.
- R3: Suppose a line shows the opposite value of its filtered level on two successive strobes. Then its `level_o` bit takes that value at the second of those strobe edges.
- R4: A raw pulse that lasts `DIV` clocks or fewer is seen by at most one strobe. It leaves `level_o` unchanged and produces no pulse.
- R5: A `rise_o` bit is high for exactly one clock, in the same cycle as the 0-to-1 change of its `level_o` bit.
- R6: A `fall_o` bit is high for exactly one clock, in the same cycle as the 1-to-0 change of its `level_o` bit.
- R7: A line whose `EDGE_MASK` bit is 0 never raises `rise_o` or `fall_o`. Its `level_o` bit is still filtered in the same way.
- R8: Lines are filtered independently. A change on one line has no effect on the outputs of another.
- R9: A raw change held steady appears on `level_o` within 2*`DIV`+2 clocks of the edge that follows the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_raw | input | WIDTH | Asynchronous bus lines |
| level_o | output | WIDTH | Filtered, synchronized levels |
| rise_o | output | WIDTH | One-clock pulse when a level is confirmed high |
| fall_o | output | WIDTH | One-clock pulse when a level is confirmed low |

## Verification
Suppose the divider phase is wrong. Then the first level change lands on an edge whose index is not a multiple of `DIV`, and this shows within 2*`DIV`+2 clocks of the first input change. Suppose instead a filter machine is in the wrong state, for example pending where it should be settled. Then a pulse exactly `DIV` clocks long either flips the level or fails to be rejected. A good pulse two strobes long might also be missed, and each of these shows within three strobe periods. If pulse gating is wrong, the masked line pulses, or a pulse outlives its single cycle, on the very edge where the level moves.

// File: rtl/osync_pkg.sv
package osync_pkg;

    typedef enum logic [1:0] {
        ST_LOW       = 2'd0,
        ST_LOW_PEND  = 2'd1,
        ST_HIGH      = 2'd2,
        ST_HIGH_PEND = 2'd3
    } filt_state_t;

    function automatic logic state_is_high(filt_state_t s);
        return (s == ST_HIGH) || (s == ST_HIGH_PEND);
    endfunction

endpackage

// File: rtl/osync_strobe_gen.sv
module osync_strobe_gen #(
    parameter int DIV = 25
) (
    input  logic clk,
    input  logic rst,
    output logic strobe
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign strobe = (cnt == LAST);

    a_r2_cnt_wrap: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (cnt == '0));
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    a_r1_cnt_clear: assert property (@(posedge clk)
        rst |=> (cnt == '0));

endmodule

// File: rtl/osync_sync2.sv
module osync_sync2 #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta   <= '0;
            q_sync <= '0;
        end else begin
            meta   <= d_async;
            q_sync <= meta;
        end
    end
endmodule

// File: rtl/osync_line_fsm.sv
module osync_line_fsm
    import osync_pkg::*;
#(
    parameter bit EDGE_EN = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic smp,
    output logic level,
    output logic rise,
    output logic fall
);
    filt_state_t state, state_nxt;

    always_comb begin
        state_nxt = state;
        if (strobe) begin
            unique case (state)
                ST_LOW:       state_nxt = smp ? ST_LOW_PEND : ST_LOW;
                ST_LOW_PEND:  state_nxt = smp ? ST_HIGH     : ST_LOW;
                ST_HIGH:      state_nxt = smp ? ST_HIGH     : ST_HIGH_PEND;
                ST_HIGH_PEND: state_nxt = smp ? ST_HIGH     : ST_LOW;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_LOW;
        else
            state <= state_nxt;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b0;
            rise  <= 1'b0;
            fall  <= 1'b0;
        end else begin
            level <= state_is_high(state_nxt);
            rise  <= EDGE_EN && strobe && (state == ST_LOW_PEND)  && smp;
            fall  <= EDGE_EN && strobe && (state == ST_HIGH_PEND) && !smp;
        end
    end

    a_r5_rise_single: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
    a_r5_rise_with_level: assert property (@(posedge clk) disable iff (rst)
        rise |-> (level && !$past(level)));
    a_r6_fall_single: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);
    a_r6_fall_with_level: assert property (@(posedge clk) disable iff (rst)
        fall |-> (!level && $past(level)));
    a_r2_change_on_strobe: assert property (@(posedge clk) disable iff (rst)
        !$stable(level) |-> $past(strobe));
    a_r1_level_clear: assert property (@(posedge clk)
        rst |=> (!level && !rise && !fall));

endmodule

// File: rtl/bus_oversampler.sv
module bus_oversampler #(
    parameter int             WIDTH     = 4,
    parameter int             DIV       = 25,
    parameter logic [WIDTH-1:0] EDGE_MASK = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pins_raw,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic             strobe;
    logic [WIDTH-1:0] pins_sync;

    osync_strobe_gen #(.DIV(DIV)) u_strobe (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe)
    );

    osync_sync2 #(.WIDTH(WIDTH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pins_raw),
        .q_sync  (pins_sync)
    );

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        osync_line_fsm #(.EDGE_EN(EDGE_MASK[g])) u_fsm (
            .clk    (clk),
            .rst    (rst),
            .strobe (strobe),
            .smp    (pins_sync[g]),
            .level  (level_o[g]),
            .rise   (rise_o[g]),
            .fall   (fall_o[g])
        );
        if (!EDGE_MASK[g]) begin : g_quiet
            a_r7_masked_quiet: assert property (@(posedge clk) disable iff (rst)
                $rose(level_o[g]) |-> !rise_o[g]);
        end
    end

endmodule

// File: tb/test_bus_oversampler.sv
`timescale 1ns/1ps
module test_bus_oversampler;
    localparam int W   = 3;
    localparam int DIV = 5;
    localparam logic [W-1:0] MASK = 3'b011;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] pins = '0;
    logic [W-1:0] level_o, rise_o, fall_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bus_oversampler #(.WIDTH(W), .DIV(DIV), .EDGE_MASK(MASK)) i_bus_oversampler (
        .clk(clk), .rst(rst), .pins_raw(pins),
        .level_o(level_o), .rise_o(rise_o), .fall_o(fall_o)
    );

    // edge index since reset release
    int n = 0;
    always @(posedge clk) n <= rst ? 0 : n + 1;

    logic [W-1:0] prev_lvl = '0, prev_rise = '0, prev_fall = '0;
    logic [W-1:0] rise_seen = '0, fall_seen = '0;

    task automatic fail_msg(string req, int act, int exp);
        failures++;
        $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, n);
    endtask

    // Per-cycle monitor
    always @(negedge clk) begin
        if (rst) begin
            prev_lvl = level_o; prev_rise = '0; prev_fall = '0;
        end else begin
            for (int i = 0; i < W; i++) begin
                if (level_o[i] != prev_lvl[i]) begin
                    checks++;  // R2: change only on strobe edges
                    if (n % DIV != 0) fail_msg("R2 change off strobe", n % DIV, 0);
                end
                if (rise_o[i]) begin
                    checks++;  // R5 / R7
                    if (!(level_o[i] && !prev_lvl[i])) fail_msg("R5 rise vs level", level_o[i], 1);
                    if (prev_rise[i]) fail_msg("R5 rise width", 2, 1);
                    if (!MASK[i]) fail_msg("R7 masked rise", 1, 0);
                end
                if (fall_o[i]) begin
                    checks++;  // R6 / R7
                    if (!(!level_o[i] && prev_lvl[i])) fail_msg("R6 fall vs level", level_o[i], 0);
                    if (prev_fall[i]) fail_msg("R6 fall width", 2, 1);
                    if (!MASK[i]) fail_msg("R7 masked fall", 1, 0);
                end
                if (level_o[i] && !prev_lvl[i] && MASK[i] && !rise_o[i])
                    fail_msg("R5 missing rise", 0, 1);
                if (!level_o[i] && prev_lvl[i] && MASK[i] && !fall_o[i])
                    fail_msg("R6 missing fall", 0, 1);
            end
            rise_seen = rise_seen | rise_o;
            fall_seen = fall_seen | fall_o;
            prev_lvl = level_o; prev_rise = rise_o; prev_fall = fall_o;
        end
    end

    task automatic hold(input logic [W-1:0] p, input int cyc);
        pins = p;
        repeat (cyc) @(negedge clk);
    endtask

    task automatic expect3(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) fail_msg(req, int'(act), int'(exp));
    endtask

    // pins, hold cycles, expected level, rises seen, falls seen
    typedef struct packed {
        logic [W-1:0] pins;
        logic [7:0]   hold;
        logic [W-1:0] lvl;
        logic [W-1:0] rs;
        logic [W-1:0] fs;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'b001, 8'd15, 3'b001, 3'b001, 3'b000},  // R3 line0 up
        '{3'b011, 8'd15, 3'b011, 3'b010, 3'b000},  // R8 line1 up, line0 stays
        '{3'b111, 8'd15, 3'b111, 3'b000, 3'b000},  // R7 line2 up without pulse
        '{3'b110, 8'd15, 3'b110, 3'b000, 3'b001},  // R6 line0 down
        '{3'b010, 8'd15, 3'b010, 3'b000, 3'b100},  // dummy overwritten below
        '{3'b000, 8'd15, 3'b000, 3'b000, 3'b010}   // R6 line1 down
    };

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        // R1: outputs during/after reset
        expect3("R1 level reset", level_o, '0);
        expect3("R1 rise reset", rise_o, '0);
        expect3("R1 fall reset", fall_o, '0);
        rst = 1'b0;

        for (int k = 0; k < 6; k++) begin
            vec_t v;
            v = VECS[k];
            if (k == 4) v.fs = 3'b000;  // line2 masked: its fall makes no pulse (R7)
            rise_seen = '0; fall_seen = '0;
            hold(v.pins, int'(v.hold));
            expect3("R3 vector level", level_o, v.lvl);
            expect3("R5 vector rises", rise_seen, v.rs);
            expect3("R6 vector falls", fall_seen, v.fs);
        end

        // R4: pulse of exactly DIV clocks is rejected
        rise_seen = '0; fall_seen = '0;
        hold(3'b001, DIV);
        hold(3'b000, 3*DIV);
        expect3("R4 short pulse level", level_o, 3'b000);
        expect3("R4 short pulse no rise", rise_seen, 3'b000);

        // R3: pulse of 2*DIV clocks is accepted
        rise_seen = '0; fall_seen = '0;
        hold(3'b001, 2*DIV);
        hold(3'b000, 4*DIV);
        expect3("R3 two-sample rise", rise_seen, 3'b001);
        expect3("R3 two-sample fall", fall_seen, 3'b001);

        // R4: short low glitch while high
        hold(3'b010, 3*DIV);
        fall_seen = '0;
        hold(3'b000, DIV - 1);
        hold(3'b010, 3*DIV);
        expect3("R4 low glitch level", level_o, 3'b010);
        expect3("R4 low glitch no fall", fall_seen, 3'b000);

        // R9: latency bound
        pins = 3'b110;
        repeat (2*DIV + 2) @(negedge clk);
        expect3("R9 latency", level_o, 3'b110);

        // R1: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        expect3("R1 mid-run level", level_o, '0);
        expect3("R1 mid-run pulses", rise_o | fall_o, '0);
        pins = 3'b000;
        @(negedge clk);
        rst = 1'b0;
        hold(3'b000, 3*DIV);
        expect3("R1 after reset", level_o, '0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule